// File: doc/BRIEF.md
# GPIO Port Configuration Registers

This block is the register file and pad-control logic for one general-purpose I/O port of up to sixteen pins. Software reaches it over a plain 32-bit register bus with separate read and write strobes and byte addresses. Each word holds packed per-pin fields: a 2-bit pin mode, a 1-bit driver type, a 2-bit slew speed, a 2-bit pull selection and a 4-bit alternate-function number. A data latch holds the pin output values. Software can write that latch whole, or change single bits atomically through a write-only set/clear word.

The pad side receives the drive enable, driven value, open-drain flag, pull-up and pull-down enables, speed code and alternate-function number for every pin. Pad levels come back through a synchronizer into a read-only input word. In alternate mode a peripheral supplies the driven value and asks for the driver through two per-pin inputs. Lock logic, analog pad circuitry and the routing of peripherals onto pins are not part of this block.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads zero, every pin is in input mode (code 0), and no pad driver is enabled.
- R2: The mode word (byte offset 0x00) holds pin p's mode at bits [2p+1:2p]: 0 input, 1 output, 2 alternate, 3 analog. In output mode the pin's driver is enabled and the pad value is the pin's data-latch bit.
- R3: Alternate-function numbers are 4 bits per pin. Pins 0-7 sit in the word at 0x20 and pins 8-15 in the word at 0x24, at bits [(p mod 8)*4+3:(p mod 8)*4]. The pad select output for pin p is bits [4p+3:4p].
- R4: A write to the set/clear word (0x18) sets latch bit n for each 1 in bit n (n<16) and clears latch bit n for each 1 in bit n+16. Zero bits leave the latch unchanged, and the word reads back as zero.
- R5: When one set/clear write both sets and clears the same bit, the bit ends up set.
- R6: The data latch (0x14) can be written whole and reads back its current value.
- R7: The input word (0x10) reports the pad levels through a two-flop synchronizer. A level applied just after a clock edge is not returned by a read whose data is captured on the following edge, but it is returned one read later. Writes to this word have no effect.
- R8: The driver-type word (0x04) holds 1 bit per pin, with 1 meaning open-drain. An open-drain pin drives low when its value is 0 and releases the pad (driver off) when its value is 1. The open-drain flag output follows the bit.
- R9: The speed word (0x08) holds 2 bits per pin at [2p+1:2p], and the pad speed output carries the same codes.
- R10: The pull word (0x0C) holds 2 bits per pin: 1 enables pull-up, 2 enables pull-down, and 0 or the reserved code 3 enables neither. The stored code reads back unchanged.
- R11: In alternate mode the driver is enabled only while the peripheral requests it, and the driven value comes from the peripheral, not from the latch.
- R12: Read data appears on the cycle after the read strobe and holds until the next read. The lock offset (0x1C) and any unmapped offset read zero, and writes to them have no effect.
- R13: In input and analog mode the pin's driver stays off, whatever the latch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NP | Raw pad levels |
| alt_oe_req | input | NP | Per-pin driver request from the alternate peripheral |
| alt_dout | input | NP | Per-pin value from the alternate peripheral |
| pad_oe | output | NP | Pad driver enable |
| pad_out | output | NP | Pad driven value |
| pad_od | output | NP | Open-drain type flag |
| pad_pu | output | NP | Pull-up enable |
| pad_pd | output | NP | Pull-down enable |
| pad_speed | output | 2*NP | Slew speed code per pin |
| pad_afsel | output | 4*NP | Alternate-function number per pin |

## Verification
The bench writes a set/clear word that both sets and clears one bit. A design that gave the clear priority would leave that bit at zero. It also writes a zero set/clear word, which must leave the latch unchanged, and reads the set/clear word back expecting zero. It reads the input word straight after a pad change: a design without the full synchronizer would show the new level one read too early, and a design that let a write reach the input word would corrupt the next read. It checks the open-drain release, the alternate-mode driver request, the reserved pull code (a design that decoded it as both pulls would fight itself), and the split of alternate-function numbers between the low and high words.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned MAX_PINS = 16;
   localparam int unsigned IDX_W    = 4;
   localparam int unsigned CLR_LSB  = 16;
   localparam int unsigned AF_W     = 4;
   localparam int unsigned AF_PER_W = 8;

   typedef enum logic [IDX_W-1:0] {
      IDX_MODE   = 4'd0,
      IDX_DRVTYP = 4'd1,
      IDX_SPEED  = 4'd2,
      IDX_PULL   = 4'd3,
      IDX_IDATA  = 4'd4,
      IDX_ODATA  = 4'd5,
      IDX_SETCLR = 4'd6,
      IDX_LOCK   = 4'd7,
      IDX_AFLO   = 4'd8,
      IDX_AFHI   = 4'd9
   } reg_idx_e;

   typedef enum logic [1:0] {
      PM_INPUT  = 2'd0,
      PM_OUTPUT = 2'd1,
      PM_ALT    = 2'd2,
      PM_ANALOG = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      PULL_NONE = 2'd0,
      PULL_UP   = 2'd1,
      PULL_DOWN = 2'd2,
      PULL_RSVD = 2'd3
   } pull_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NP = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     idx,
   input  logic [31:0]          wdata,
   output logic [2*NP-1:0]      mode_q,
   output logic [NP-1:0]        drvtyp_q,
   output logic [2*NP-1:0]      speed_q,
   output logic [2*NP-1:0]      pull_q,
   output logic [AF_W*NP-1:0]   af_q
);

   for (genvar p = 0; p < NP; p++) begin : g_pin
      localparam logic [IDX_W-1:0] AF_IDX = (p < AF_PER_W) ? IDX_AFLO : IDX_AFHI;
      localparam int unsigned      AF_LSB = (p % AF_PER_W) * AF_W;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[2*p +: 2]     <= PM_INPUT;
            drvtyp_q[p]          <= 1'b0;
            speed_q[2*p +: 2]    <= 2'd0;
            pull_q[2*p +: 2]     <= PULL_NONE;
            af_q[AF_W*p +: AF_W] <= '0;
         end else if (wr_en) begin
            if (idx == IDX_MODE)   mode_q[2*p +: 2]  <= wdata[2*p +: 2];
            if (idx == IDX_DRVTYP) drvtyp_q[p]       <= wdata[p];
            if (idx == IDX_SPEED)  speed_q[2*p +: 2] <= wdata[2*p +: 2];
            if (idx == IDX_PULL)   pull_q[2*p +: 2]  <= wdata[2*p +: 2];
            if (idx == AF_IDX)     af_q[AF_W*p +: AF_W] <= wdata[AF_LSB +: AF_W];
         end
      end
   end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
   import gpio_port_pkg::*;
#(
   parameter int unsigned NP = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_whole,
   input  logic           wr_setclr,
   input  logic [31:0]    wdata,
   output logic [NP-1:0]  odr_q
);

   logic [NP-1:0] set_bits;
   logic [NP-1:0] clr_bits;
   logic [NP-1:0] odr_d;

   assign set_bits = wdata[NP-1:0];
   assign clr_bits = wdata[CLR_LSB +: NP];

   // set wins over clear: clear is applied first, set is ORed in after
   always_comb begin
      odr_d = odr_q;
      if (wr_whole)       odr_d = wdata[NP-1:0];
      else if (wr_setclr) odr_d = (odr_q & ~clr_bits) | set_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) odr_q <= '0;
      else        odr_q <= odr_d;
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned NP     = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NP-1:0]  raw,
   output logic [NP-1:0]  synced
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [NP-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign synced = chain[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import gpio_port_pkg::*;
#(
   parameter int unsigned NP = 16
) (
   input  logic [2*NP-1:0] mode_q,
   input  logic [NP-1:0]   drvtyp_q,
   input  logic [2*NP-1:0] pull_q,
   input  logic [NP-1:0]   odr_q,
   input  logic [NP-1:0]   alt_oe_req,
   input  logic [NP-1:0]   alt_dout,
   output logic [NP-1:0]   pad_oe,
   output logic [NP-1:0]   pad_out,
   output logic [NP-1:0]   pad_od,
   output logic [NP-1:0]   pad_pu,
   output logic [NP-1:0]   pad_pd
);

   for (genvar p = 0; p < NP; p++) begin : g_pin
      pin_mode_e pm;
      pull_e     pl;
      logic      drv_en;
      logic      val;

      assign pm = pin_mode_e'(mode_q[2*p +: 2]);
      assign pl = pull_e'(pull_q[2*p +: 2]);

      always_comb begin
         drv_en = 1'b0;
         val    = odr_q[p];
         case (pm)
            PM_OUTPUT: drv_en = 1'b1;
            PM_ALT: begin
               drv_en = alt_oe_req[p];
               val    = alt_dout[p];
            end
            default:   drv_en = 1'b0;
         endcase
      end

      // open-drain: drive only a low, release on a high
      assign pad_oe[p]  = drv_en & ~(drvtyp_q[p] & val);
      assign pad_out[p] = val & ~drvtyp_q[p];
      assign pad_od[p]  = drvtyp_q[p];
      assign pad_pu[p]  = (pl == PULL_UP);
      assign pad_pd[p]  = (pl == PULL_DOWN);
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NP          = 16,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NP-1:0]     pad_in,
   input  logic [NP-1:0]     alt_oe_req,
   input  logic [NP-1:0]     alt_dout,
   output logic [NP-1:0]     pad_oe,
   output logic [NP-1:0]     pad_out,
   output logic [NP-1:0]     pad_od,
   output logic [NP-1:0]     pad_pu,
   output logic [NP-1:0]     pad_pd,
   output logic [2*NP-1:0]   pad_speed,
   output logic [4*NP-1:0]   pad_afsel
);

   localparam int unsigned WIDX_W = ADDR_W - 2;

   if (NP < 1 || NP > MAX_PINS) begin : g_bad_np
      $error("gpio_port_regs: NP must be 1..16");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("gpio_port_regs: ADDR_W too small for the register map");
   end

   logic [WIDX_W-1:0]   widx;
   logic                in_map;
   logic [IDX_W-1:0]    idx;
   logic                wr_hit;
   logic [2*NP-1:0]     mode_q;
   logic [NP-1:0]       drvtyp_q;
   logic [2*NP-1:0]     speed_q;
   logic [2*NP-1:0]     pull_q;
   logic [AF_W*NP-1:0]  af_q;
   logic [NP-1:0]       odr_q;
   logic [NP-1:0]       idr_s;
   logic [31:0]         af_lo_word;
   logic [31:0]         af_hi_word;
   logic [31:0]         rd_word;

   assign widx   = bus_addr[ADDR_W-1:2];
   assign in_map = (widx <= WIDX_W'(IDX_AFHI));
   assign idx    = in_map ? widx[IDX_W-1:0] : IDX_LOCK;
   assign wr_hit = bus_wr & in_map;

   gpio_cfg_regs #(.NP(NP)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit),
      .idx      (idx),
      .wdata    (bus_wdata),
      .mode_q   (mode_q),
      .drvtyp_q (drvtyp_q),
      .speed_q  (speed_q),
      .pull_q   (pull_q),
      .af_q     (af_q)
   );

   gpio_out_latch #(.NP(NP)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_whole  (wr_hit && idx == IDX_ODATA),
      .wr_setclr (wr_hit && idx == IDX_SETCLR),
      .wdata     (bus_wdata),
      .odr_q     (odr_q)
   );

   gpio_in_sync #(.NP(NP), .STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (pad_in),
      .synced (idr_s)
   );

   gpio_pad_drive #(.NP(NP)) i_drive (
      .mode_q     (mode_q),
      .drvtyp_q   (drvtyp_q),
      .pull_q     (pull_q),
      .odr_q      (odr_q),
      .alt_oe_req (alt_oe_req),
      .alt_dout   (alt_dout),
      .pad_oe     (pad_oe),
      .pad_out    (pad_out),
      .pad_od     (pad_od),
      .pad_pu     (pad_pu),
      .pad_pd     (pad_pd)
   );

   assign pad_speed = speed_q;
   assign pad_afsel = af_q;

   always_comb begin
      af_lo_word = '0;
      af_hi_word = '0;
      for (int p = 0; p < int'(NP); p++) begin
         if (p < int'(AF_PER_W))
            af_lo_word[(p % AF_PER_W)*AF_W +: AF_W] = af_q[AF_W*p +: AF_W];
         else
            af_hi_word[(p % AF_PER_W)*AF_W +: AF_W] = af_q[AF_W*p +: AF_W];
      end
   end

   always_comb begin
      rd_word = '0;
      case (idx)
         IDX_MODE:   rd_word[2*NP-1:0] = mode_q;
         IDX_DRVTYP: rd_word[NP-1:0]   = drvtyp_q;
         IDX_SPEED:  rd_word[2*NP-1:0] = speed_q;
         IDX_PULL:   rd_word[2*NP-1:0] = pull_q;
         IDX_IDATA:  rd_word[NP-1:0]   = idr_s;
         IDX_ODATA:  rd_word[NP-1:0]   = odr_q;
         IDX_AFLO:   rd_word           = af_lo_word;
         IDX_AFHI:   rd_word           = af_hi_word;
         default:    rd_word           = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
   end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned NP     = 16,
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NP-1:0]     pad_oe,
   input logic [NP-1:0]     pad_out,
   input logic [NP-1:0]     pad_od,
   input logic [NP-1:0]     pad_pu,
   input logic [NP-1:0]     pad_pd,
   input logic [2*NP-1:0]   mode_q,
   input logic [NP-1:0]     odr_q
);

   logic setclr_wr;
   assign setclr_wr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_SETCLR));

   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setclr_wr |=> ((odr_q & $past(bus_wdata[NP-1:0])) == $past(bus_wdata[NP-1:0])));

   // R4
   zero_setclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setclr_wr && bus_wdata == 32'd0) |=> $stable(odr_q));

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R8
   od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_od & pad_oe & pad_out) == '0));

   // R10
   pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_pd) == '0));

   for (genvar p = 0; p < NP; p++) begin : g_pin
      // R13
      idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[2*p +: 2] == PM_INPUT || mode_q[2*p +: 2] == PM_ANALOG) |-> !pad_oe[p]);
   end

endmodule

bind gpio_port_regs gpio_port_chk #(.NP(NP), .ADDR_W(ADDR_W)) i_gpio_port_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_od    (pad_od),
   .pad_pu    (pad_pu),
   .pad_pd    (pad_pd),
   .mode_q    (mode_q),
   .odr_q     (odr_q)
);

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

   localparam int NP = 16;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] alt_oe_req = '0;
   logic [NP-1:0] alt_dout = '0;
   logic [NP-1:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd;
   logic [2*NP-1:0] pad_speed;
   logic [4*NP-1:0] pad_afsel;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   gpio_port_regs #(.NP(NP), .ADDR_W(AW), .SYNC_STAGES(2)) i_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .alt_oe_req(alt_oe_req), .alt_dout(alt_dout),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
      .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_speed(pad_speed),
      .pad_afsel(pad_afsel)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a[AW-1:0];
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); chk("R1 mode", 64'(d), 64'h0);
      rd(8'h14, d); chk("R1 latch", 64'(d), 64'h0);
      rd(8'h20, d); chk("R1 aflo", 64'(d), 64'h0);
      chk("R1 oe", 64'(pad_oe), 64'h0);
      chk("R1 pulls", 64'({pad_pu, pad_pd}), 64'h0);
   endtask

   task automatic t_mode();
      logic [31:0] d;
      wr(8'h00, 32'h4000_0001);
      wr(8'h14, 32'h0000_8001);
      chk("R2 oe", 64'(pad_oe), 64'h8001);
      chk("R2 out", 64'(pad_out), 64'h8001);
      rd(8'h00, d); chk("R2 readback", 64'(d), 64'h4000_0001);
      wr(8'h14, 32'h0000_0001);
      chk("R6 out", 64'(pad_out), 64'h0001);
      rd(8'h14, d); chk("R6 readback", 64'(d), 64'h0001);
   endtask

   task automatic t_setclr();
      logic [31:0] d;
      wr(8'h14, 32'h0);
      wr(8'h18, 32'h0000_00F0);
      rd(8'h14, d); chk("R4 set", 64'(d), 64'h00F0);
      wr(8'h18, 32'h0030_0000);
      rd(8'h14, d); chk("R4 clear", 64'(d), 64'h00C0);
      wr(8'h18, 32'h0);
      rd(8'h14, d); chk("R4 zero write", 64'(d), 64'h00C0);
      rd(8'h18, d); chk("R4 reads zero", 64'(d), 64'h0);
      wr(8'h18, 32'h00C1_0081);
      rd(8'h14, d); chk("R5 set priority", 64'(d), 64'h0081);
   endtask

   task automatic t_input();
      logic [31:0] d;
      @(negedge clk);
      pad_in = 16'hA5C3;
      rd(8'h10, d); chk("R7 not yet visible", 64'(d), 64'h0);
      rd(8'h10, d); chk("R7 visible", 64'(d), 64'hA5C3);
      wr(8'h10, 32'h0000_0000);
      rd(8'h10, d); chk("R7 write ignored", 64'(d), 64'hA5C3);
   endtask

   task automatic t_opendrain();
      wr(8'h00, 32'h0000_0010);
      wr(8'h04, 32'h0000_0004);
      wr(8'h14, 32'h0000_0004);
      chk("R8 release high", 64'(pad_oe), 64'h0);
      chk("R8 od flag", 64'(pad_od), 64'h0004);
      wr(8'h14, 32'h0000_0000);
      chk("R8 drive low oe", 64'(pad_oe), 64'h0004);
      chk("R8 drive low val", 64'(pad_out), 64'h0);
      wr(8'h04, 32'h0);
   endtask

   task automatic t_speed_pull();
      logic [31:0] d;
      wr(8'h08, 32'h0000_00E4);
      chk("R9 speed", 64'(pad_speed), 64'h0000_00E4);
      wr(8'h0C, 32'h0000_00E4);
      chk("R10 pull-up", 64'(pad_pu), 64'h0002);
      chk("R10 pull-down", 64'(pad_pd), 64'h0004);
      rd(8'h0C, d); chk("R10 readback", 64'(d), 64'h00E4);
   endtask

   task automatic t_alt();
      logic [31:0] d;
      wr(8'h20, 32'h7654_3210);
      wr(8'h24, 32'hFEDC_BA98);
      chk("R3 select", pad_afsel, 64'hFEDC_BA98_7654_3210);
      rd(8'h24, d); chk("R3 high readback", 64'(d), 64'hFEDC_BA98);
      wr(8'h00, 32'h0000_0200);
      wr(8'h14, 32'h0);
      alt_oe_req = 16'h0010; alt_dout = 16'h0010;
      #1;
      chk("R11 oe", 64'(pad_oe), 64'h0010);
      chk("R11 value", 64'(pad_out), 64'h0010);
      alt_oe_req = 16'h0;
      #1;
      chk("R11 no request", 64'(pad_oe), 64'h0);
      alt_dout = 16'h0;
   endtask

   task automatic t_idle_and_map();
      logic [31:0] d;
      wr(8'h00, 32'h0000_0003);
      wr(8'h14, 32'h0000_0001);
      chk("R13 analog off", 64'(pad_oe), 64'h0);
      wr(8'h00, 32'h0000_0000);
      chk("R13 input off", 64'(pad_oe), 64'h0);
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h1C, d); chk("R12 lock zero", 64'(d), 64'h0);
      rd(8'h28, d); chk("R12 unmapped zero", 64'(d), 64'h0);
      rd(8'h00, d); chk("R12 map intact", 64'(d), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mode();
      t_setclr();
      t_input();
      t_opendrain();
      t_speed_pull();
      t_alt();
      t_idle_and_map();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule